// File: doc/BRIEF.md
# SPI Flash Chunked Read Sequencer

This block copies a run of bytes from a serial NOR flash into a local byte-wide memory without any processor help. A request gives a 24-bit flash address, a byte count and a destination address. The engine splits the request into bursts that fit its 64-byte receive buffer. For each burst it lowers chip select and sends the standard single-lane read command (0x03) followed by the address. It keeps clocking until the whole burst has been received, then raises chip select. It throws away the four bytes that arrived while the header was being sent and writes the remaining bytes to the destination memory, one per cycle.

Between bursts the flash address and the destination pointer both move forward by the chunk just copied. Chip select is then held high for a programmable minimum time before the next burst begins. The serial clock is SPI mode 0: it idles low, the flash samples on the rising edge, and the engine shifts out on the falling edge. Its half period is a parameter counted in system clock cycles.

Top module: `spi_chunk_reader`

## Requirements
- R1: After reset, busy_o, done_o, spi_sck_o and mem_we_o are 0 and spi_cs_n_o is 1.
- R2: Every burst shifts out, most significant bit first, the byte 0x03 and then the three address bytes from the high byte to the low byte. MOSI changes only on falling SCK edges, and SCK stays low while chip select is high.
- R3: No burst carries more than 60 data bytes. A request of L bytes uses ceil(L/60) bursts, and every burst but the last carries 60 data bytes. Each burst clocks exactly 4 + chunk bytes, and the last burst carries the remainder.
- R4: The first 4 bytes received in every burst are discarded. Byte i of the request, read from flash address addr_i+i (modulo 2^24), is written to memory address dst_i+i. No write falls outside dst_i .. dst_i+len_i-1, and there are exactly len_i writes.
- R5: Each burst after the first starts at the previous burst's flash address plus the previous chunk length.
- R6: Between the end of one burst and the start of the next, chip select stays high for at least GAP_CYCLES clock cycles. This holds both within a request and across back-to-back requests.
- R7: A request with len_i = 0 raises done_o in the next cycle. busy_o never rises and chip select never falls.
- R8: For a nonzero length, busy_o is high from the cycle after start_i until the last memory write. done_o is a single-cycle pulse in the cycle after the last write, and busy_o is low while it is high.
- R9: start_i is ignored while busy_o is high, and the running transfer completes unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request strobe, taken while idle |
| addr_i | input | ADDR_W | Flash start address |
| len_i | input | LEN_W | Number of bytes to copy |
| dst_i | input | DST_W | Destination memory start address |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle completion pulse |
| spi_cs_n_o | output | 1 | Flash chip select, active low |
| spi_sck_o | output | 1 | Serial clock, mode 0 |
| spi_mosi_o | output | 1 | Serial data to flash |
| spi_miso_i | input | 1 | Serial data from flash |
| mem_we_o | output | 1 | Memory write strobe |
| mem_addr_o | output | DST_W | Memory write address |
| mem_data_o | output | 8 | Memory write data |

## Verification
Assertions check these on every cycle: the deselect gap before each falling chip select, SCK low while deselected, done lasting one cycle, writes occurring only while busy, chip select high whenever idle, and the receive buffer never overflowing or underflowing. Only the bench's scenarios can show that the command and address bytes are correct for each burst, that the chunk count and remainder sizes match the request, and that the header bytes are dropped so that data lands at the right destination. The same holds for the zero-length request, for address wrap at the top of flash, and for a start pulse that must be ignored mid-transfer. A flash model in the bench captures each burst's header and serves a computed byte pattern.

// File: rtl/scr_pkg.sv
package scr_pkg;
    localparam logic [7:0] READ_CMD  = 8'h03;
    localparam int         HDR_BYTES = 4;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LAUNCH,
        ST_SEND,
        ST_WAIT,
        ST_DRAIN
    } scr_state_e;
endpackage

// File: rtl/scr_bit_shifter.sv
module scr_bit_shifter #(
    parameter int DIV = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       go_i,
    input  logic [7:0] tx_i,
    input  logic       miso_i,
    output logic       sck_o,
    output logic       mosi_o,
    output logic [7:0] rx_o,
    output logic       done_o
);
    localparam int CNT_W = (DIV > 1) ? $clog2(DIV) : 1;

    typedef struct packed {
        logic             active;
        logic             sck;
        logic [CNT_W-1:0] cnt;
        logic [2:0]       nbit;
        logic [7:0]       tx;
        logic [7:0]       rx;
        logic             done;
    } shf_t;

    shf_t sh_q, sh_d;

    always_comb begin
        sh_d      = sh_q;
        sh_d.done = 1'b0;
        if (go_i && !sh_q.active) begin
            sh_d.active = 1'b1;
            sh_d.sck    = 1'b0;
            sh_d.cnt    = '0;
            sh_d.nbit   = '0;
            sh_d.tx     = tx_i;
        end else if (sh_q.active) begin
            if (sh_q.cnt == CNT_W'(DIV - 1)) begin
                sh_d.cnt = '0;
                if (!sh_q.sck) begin
                    sh_d.sck = 1'b1;
                    sh_d.rx  = {sh_q.rx[6:0], miso_i};
                end else begin
                    sh_d.sck  = 1'b0;
                    sh_d.tx   = {sh_q.tx[6:0], 1'b0};
                    sh_d.nbit = sh_q.nbit + 3'd1;
                    if (sh_q.nbit == 3'd7) begin
                        sh_d.active = 1'b0;
                        sh_d.done   = 1'b1;
                    end
                end
            end else begin
                sh_d.cnt = sh_q.cnt + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign sck_o  = sh_q.sck;
    assign mosi_o = sh_q.tx[7];
    assign rx_o   = sh_q.rx;
    assign done_o = sh_q.done;

    AST_GO_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        go_i |-> !sh_q.active); // R2
    AST_MOSI_HOLD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (sh_q.sck && sh_d.sck) |=> $stable(mosi_o)); // R2
endmodule

// File: rtl/scr_rx_fifo.sv
module scr_rx_fifo #(
    parameter int DEPTH = 64
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         push_i,
    input  logic [7:0]                   data_i,
    input  logic                         pop_i,
    output logic [7:0]                   data_o,
    output logic [$clog2(DEPTH+1)-1:0]   level_o
);
    localparam int PTR_W = $clog2(DEPTH);
    localparam int LVL_W = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [PTR_W-1:0] wr;
        logic [PTR_W-1:0] rd;
        logic [LVL_W-1:0] lvl;
    } fifo_t;

    fifo_t      f_q, f_d;
    logic [7:0] store [DEPTH];

    always_comb begin
        f_d = f_q;
        if (push_i) f_d.wr = (f_q.wr == PTR_W'(DEPTH - 1)) ? '0 : f_q.wr + PTR_W'(1);
        if (pop_i)  f_d.rd = (f_q.rd == PTR_W'(DEPTH - 1)) ? '0 : f_q.rd + PTR_W'(1);
        case ({push_i, pop_i})
            2'b10:   f_d.lvl = f_q.lvl + LVL_W'(1);
            2'b01:   f_d.lvl = f_q.lvl - LVL_W'(1);
            default: f_d.lvl = f_q.lvl;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) f_q <= '0;
        else        f_q <= f_d;
    end

    always_ff @(posedge clk) begin
        if (push_i) store[f_q.wr] <= data_i;
    end

    assign data_o  = store[f_q.rd];
    assign level_o = f_q.lvl;

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        push_i |-> (f_q.lvl < LVL_W'(DEPTH))); // R3
    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        pop_i |-> (f_q.lvl != '0)); // R4
endmodule

// File: rtl/spi_chunk_reader.sv
module spi_chunk_reader
    import scr_pkg::*;
#(
    parameter int ADDR_W     = 24,
    parameter int LEN_W      = 16,
    parameter int DST_W      = 16,
    parameter int MAX_CHUNK  = 60,
    parameter int CLK_DIV    = 2,
    parameter int GAP_CYCLES = 25
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [LEN_W-1:0]  len_i,
    input  logic [DST_W-1:0]  dst_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              spi_cs_n_o,
    output logic              spi_sck_o,
    output logic              spi_mosi_o,
    input  logic              spi_miso_i,
    output logic              mem_we_o,
    output logic [DST_W-1:0]  mem_addr_o,
    output logic [7:0]        mem_data_o
);
    localparam int FIFO_DEPTH = MAX_CHUNK + HDR_BYTES;
    localparam int LVL_W      = $clog2(FIFO_DEPTH + 1);
    localparam int CH_W       = $clog2(MAX_CHUNK + 1);
    localparam int GAP_W      = $clog2(GAP_CYCLES + 1);

    typedef struct packed {
        scr_state_e        state;
        logic [ADDR_W-1:0] addr;
        logic [DST_W-1:0]  dst;
        logic [LEN_W-1:0]  remain;
        logic [CH_W-1:0]   chunk;
        logic [LVL_W-1:0]  idx;
        logic [7:0]        tx;
        logic              go;
        logic              cs_n;
        logic [GAP_W-1:0]  gap;
        logic              done;
    } ctl_t;

    ctl_t ctl_q, ctl_d;

    logic             sh_done;
    logic [7:0]       sh_rx;
    logic             fifo_pop;
    logic [7:0]       fifo_head;
    logic [LVL_W-1:0] fifo_lvl;
    logic [LVL_W-1:0] burst_len;
    logic [LEN_W-1:0] remain_next;

    function automatic logic [CH_W-1:0] chunk_of(input logic [LEN_W-1:0] left);
        return (left > LEN_W'(MAX_CHUNK)) ? CH_W'(MAX_CHUNK) : CH_W'(left);
    endfunction

    function automatic logic [7:0] header_byte(input logic [LVL_W-1:0] pos,
                                               input logic [ADDR_W-1:0] a);
        logic [23:0] a24;
        a24 = 24'(a);
        case (pos)
            LVL_W'(0): return READ_CMD;
            LVL_W'(1): return a24[23:16];
            LVL_W'(2): return a24[15:8];
            LVL_W'(3): return a24[7:0];
            default:   return 8'h00;
        endcase
    endfunction

    assign burst_len   = LVL_W'(HDR_BYTES) + LVL_W'(ctl_q.chunk);
    assign remain_next = ctl_q.remain - LEN_W'(ctl_q.chunk);
    assign fifo_pop    = (ctl_q.state == ST_DRAIN);

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.go   = 1'b0;
        ctl_d.done = 1'b0;
        if (ctl_q.cs_n)
            ctl_d.gap = (ctl_q.gap == GAP_W'(GAP_CYCLES)) ? ctl_q.gap : ctl_q.gap + GAP_W'(1);
        else
            ctl_d.gap = '0;

        case (ctl_q.state)
            ST_IDLE: begin
                if (start_i) begin
                    if (len_i == '0) begin
                        ctl_d.done = 1'b1;
                    end else begin
                        ctl_d.addr   = addr_i;
                        ctl_d.dst    = dst_i;
                        ctl_d.remain = len_i;
                        ctl_d.chunk  = chunk_of(len_i);
                        ctl_d.state  = ST_LAUNCH;
                    end
                end
            end
            ST_LAUNCH: begin
                if (ctl_q.gap == GAP_W'(GAP_CYCLES)) begin
                    ctl_d.cs_n  = 1'b0;
                    ctl_d.go    = 1'b1;
                    ctl_d.tx    = header_byte('0, ctl_q.addr);
                    ctl_d.idx   = '0;
                    ctl_d.state = ST_SEND;
                end
            end
            ST_SEND: begin
                if (sh_done) begin
                    ctl_d.idx = ctl_q.idx + LVL_W'(1);
                    if (ctl_d.idx == burst_len) begin
                        ctl_d.cs_n  = 1'b1;
                        ctl_d.state = ST_WAIT;
                    end else begin
                        ctl_d.go = 1'b1;
                        ctl_d.tx = header_byte(ctl_d.idx, ctl_q.addr);
                    end
                end
            end
            ST_WAIT: begin
                if (fifo_lvl >= burst_len) begin
                    ctl_d.idx   = '0;
                    ctl_d.state = ST_DRAIN;
                end
            end
            ST_DRAIN: begin
                ctl_d.idx = ctl_q.idx + LVL_W'(1);
                if (ctl_q.idx == burst_len - LVL_W'(1)) begin
                    ctl_d.addr   = ctl_q.addr + ADDR_W'(ctl_q.chunk);
                    ctl_d.dst    = ctl_q.dst + DST_W'(ctl_q.chunk);
                    ctl_d.remain = remain_next;
                    if (remain_next == '0) begin
                        ctl_d.done  = 1'b1;
                        ctl_d.state = ST_IDLE;
                    end else begin
                        ctl_d.chunk = chunk_of(remain_next);
                        ctl_d.state = ST_LAUNCH;
                    end
                end
            end
            default: ctl_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q       <= '0;
            ctl_q.state <= ST_IDLE;
            ctl_q.cs_n  <= 1'b1;
            ctl_q.gap   <= GAP_W'(GAP_CYCLES);
        end else begin
            ctl_q <= ctl_d;
        end
    end

    scr_bit_shifter #(.DIV(CLK_DIV)) u_shift (
        .clk    (clk),
        .rst_n  (rst_n),
        .go_i   (ctl_q.go),
        .tx_i   (ctl_q.tx),
        .miso_i (spi_miso_i),
        .sck_o  (spi_sck_o),
        .mosi_o (spi_mosi_o),
        .rx_o   (sh_rx),
        .done_o (sh_done)
    );

    scr_rx_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
        .clk     (clk),
        .rst_n   (rst_n),
        .push_i  (sh_done),
        .data_i  (sh_rx),
        .pop_i   (fifo_pop),
        .data_o  (fifo_head),
        .level_o (fifo_lvl)
    );

    assign busy_o     = (ctl_q.state != ST_IDLE);
    assign done_o     = ctl_q.done;
    assign spi_cs_n_o = ctl_q.cs_n;
    assign mem_we_o   = fifo_pop && (ctl_q.idx >= LVL_W'(HDR_BYTES));
    assign mem_addr_o = ctl_q.dst + DST_W'(ctl_q.idx) - DST_W'(HDR_BYTES);
    assign mem_data_o = fifo_head;

    // Independent deselect-time counter for the gap check
    logic [GAP_W-1:0] chk_hi_q;
    logic             chk_seen_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chk_hi_q   <= '0;
            chk_seen_q <= 1'b0;
        end else if (spi_cs_n_o) begin
            if (chk_hi_q != GAP_W'(GAP_CYCLES)) chk_hi_q <= chk_hi_q + GAP_W'(1);
        end else begin
            chk_hi_q   <= '0;
            chk_seen_q <= 1'b1;
        end
    end

    AST_CS_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(spi_cs_n_o) && chk_seen_q) |-> (chk_hi_q >= GAP_W'(GAP_CYCLES))); // R6
    AST_SCK_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        spi_cs_n_o |-> !spi_sck_o); // R2
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R8
    AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o); // R8
    AST_WRITE_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we_o |-> busy_o); // R4
    AST_IDLE_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> spi_cs_n_o); // R7
endmodule

// File: tb/spi_chunk_reader_test.sv
module spi_chunk_reader_test;
    localparam int GAP = 25;
    localparam int MAXC = 60;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [23:0] addr_i = '0;
    logic [15:0] len_i = '0;
    logic [15:0] dst_i = '0;
    logic        busy_o, done_o, spi_cs_n_o, spi_sck_o, spi_mosi_o;
    logic        spi_miso_i = 1'b0;
    logic        mem_we_o;
    logic [15:0] mem_addr_o;
    logic [7:0]  mem_data_o;

    always #2 clk = ~clk;

    spi_chunk_reader #(.MAX_CHUNK(MAXC), .GAP_CYCLES(GAP)) uut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .addr_i(addr_i),
        .len_i(len_i), .dst_i(dst_i), .busy_o(busy_o), .done_o(done_o),
        .spi_cs_n_o(spi_cs_n_o), .spi_sck_o(spi_sck_o), .spi_mosi_o(spi_mosi_o),
        .spi_miso_i(spi_miso_i), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
        .mem_data_o(mem_data_o)
    );

    int total = 0;
    int bad = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] fbyte(input logic [23:0] a);
        return a[7:0] ^ a[15:8] ^ {a[22:16], 1'b1} ^ 8'h5A;
    endfunction

    // Flash model
    logic [7:0]  f_sr;
    logic [7:0]  f_cmd;
    logic [23:0] f_addr;
    int          f_bits;
    bit          in_req = 0;
    int          bursts;
    logic [23:0] exp_faddr;
    int          exp_rem;

    always @(negedge spi_cs_n_o) f_bits = 0;

    always @(posedge spi_sck_o) begin
        f_sr = {f_sr[6:0], spi_mosi_o};
        f_bits++;
        if (f_bits == 8)  f_cmd = f_sr;
        if (f_bits == 16) f_addr[23:16] = f_sr;
        if (f_bits == 24) f_addr[15:8] = f_sr;
        if (f_bits == 32) f_addr[7:0] = f_sr;
    end

    always @(negedge spi_sck_o) begin
        if (!spi_cs_n_o && f_bits >= 32) begin
            logic [7:0] b;
            b = fbyte(f_addr + 24'(f_bits / 8 - 4));
            spi_miso_i = b[7 - (f_bits % 8)];
        end
    end

    always @(posedge spi_cs_n_o) begin
        if (in_req) begin
            int ch;
            ch = (exp_rem > MAXC) ? MAXC : exp_rem;
            bursts++;
            chk(f_cmd == 8'h03, "R2", "command byte", int'(f_cmd), 3);
            chk(f_addr == exp_faddr, "R5", "burst address", int'(f_addr), int'(exp_faddr));
            chk(f_bits == 8 * (4 + ch), "R3", "bits per burst", f_bits, 8 * (4 + ch));
            exp_faddr = exp_faddr + 24'(ch);
            exp_rem   = exp_rem - ch;
        end
    end

    // Deselect gap monitor
    int hi_cnt = 0;
    bit seen_low = 0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (spi_cs_n_o) hi_cnt++;
            else begin
                if (seen_low && hi_cnt > 0)
                    chk(hi_cnt >= GAP, "R6", "deselect cycles", hi_cnt, GAP);
                hi_cnt = 0;
                seen_low = 1;
            end
        end
    end

    // Memory model
    logic [7:0] bmem [0:65535];
    int wr_cnt, oor, cur_dst, cur_len;
    always @(negedge clk) begin
        if (rst_n && mem_we_o) begin
            bmem[mem_addr_o] = mem_data_o;
            wr_cnt++;
            if (int'(mem_addr_o) < cur_dst || int'(mem_addr_o) >= cur_dst + cur_len) oor++;
        end
    end

    task automatic run_req(input logic [23:0] a, input int l, input int d, input bit poke);
        int cyc;
        int errs;
        bit busy_ok;
        exp_faddr = a; exp_rem = l; cur_dst = d; cur_len = l;
        wr_cnt = 0; oor = 0; bursts = 0; in_req = 1;
        @(negedge clk);
        start_i = 1; addr_i = a; len_i = 16'(l); dst_i = 16'(d);
        @(negedge clk);
        start_i = 0;
        if (l == 0) begin
            chk(done_o == 1'b1, "R7", "done after zero length", int'(done_o), 1);
            chk(busy_o == 1'b0, "R7", "busy on zero length", int'(busy_o), 0);
            @(negedge clk);
            chk(done_o == 1'b0, "R8", "done pulse width", int'(done_o), 0);
            repeat (5) @(negedge clk);
            chk(bursts == 0 && spi_cs_n_o, "R7", "bursts on zero length", bursts, 0);
            in_req = 0;
            return;
        end
        chk(busy_o == 1'b1, "R8", "busy after start", int'(busy_o), 1);
        cyc = 0; busy_ok = 1;
        while (!done_o && cyc < 20000) begin
            busy_ok &= busy_o;
            if (poke && (cyc == 40 || cyc == 900)) begin
                start_i = 1; addr_i = ~a; len_i = 16'd3; dst_i = 16'(d + 7);
            end else start_i = 0;
            @(negedge clk);
            cyc++;
        end
        start_i = 0;
        chk(busy_ok, "R8", "busy held until last write", int'(busy_ok), 1);
        chk(done_o == 1'b1, "R8", "done reached", int'(done_o), 1);
        chk(busy_o == 1'b0, "R8", "busy low with done", int'(busy_o), 0);
        chk(wr_cnt == l, "R4", "write count", wr_cnt, l);
        chk(oor == 0, "R4", "writes outside range", oor, 0);
        errs = 0;
        for (int i = 0; i < l; i++)
            if (bmem[16'(d + i)] !== fbyte(a + 24'(i))) errs++;
        chk(errs == 0, "R4", "data mismatches", errs, 0);
        chk(bursts == (l + MAXC - 1) / MAXC, "R3", "burst count", bursts, (l + MAXC - 1) / MAXC);
        if (poke) chk(errs == 0 && wr_cnt == l, "R9", "start while busy ignored", errs, 0);
        @(negedge clk);
        chk(done_o == 1'b0, "R8", "done pulse width", int'(done_o), 0);
        in_req = 0;
    endtask

    initial begin
        #760000;
        chk(0, "R8", "watchdog expired", 0, 1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd2718));
        repeat (5) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk(busy_o == 0, "R1", "busy at reset", int'(busy_o), 0);
        chk(done_o == 0, "R1", "done at reset", int'(done_o), 0);
        chk(spi_cs_n_o == 1, "R1", "cs_n at reset", int'(spi_cs_n_o), 1);
        chk(spi_sck_o == 0, "R1", "sck at reset", int'(spi_sck_o), 0);
        chk(mem_we_o == 0, "R1", "write strobe at reset", int'(mem_we_o), 0);

        run_req(24'h000100, 0, 100, 0);       // R7
        run_req(24'h012345, 1, 200, 0);       // single byte
        run_req(24'h0000F0, 60, 300, 0);      // exactly one full chunk
        run_req(24'h0001F8, 61, 400, 0);      // remainder of one byte
        run_req(24'hFFFFE0, 120, 600, 0);     // R5 address wrap across two bursts
        run_req(24'h00ABCD, 150, 900, 1);     // R9 start pulses while busy
        run_req(24'h003000, 0, 100, 0);       // R7 again between transfers
        for (int k = 0; k < 10; k++) begin
            int l;
            l = $urandom_range(1, 170);
            run_req(24'($urandom), l, $urandom_range(0, 65535 - l), 0);
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule